// File: doc/BRIEF.md
# 100BASE-TX Receive Frame Decapsulator

This block sits between the line-side symbol decoder and the receive MAC logic. Each accepted line symbol is tagged as a data byte, a start-of-stream code (JK), an end-of-stream code (TR) or idle. The block hunts for a JK code and then skips the remaining preamble bytes. The first start-frame-delimiter byte opens the frame. Every frame byte from the destination address onward goes out on a simple valid/last byte port.

The four trailing frame check sequence bytes are held back in a short delay line and never forwarded. When the stream ends, the last forwarded byte carries the frame status. That status gives a CRC error flag and a length-or-type classification of the two bytes after the source address. A frame that stops without a TR code counts as a CRC error. A broken preamble makes the block drop the attempt and wait for the next JK code.

Top module: `rx_frame_decap`

## Requirements
- R1: After reset, and until a frame ends, `frm_valid`, `frm_last`, `frm_crc_bad` and `frm_is_length` are all 0.
- R2: Symbols that arrive before a JK code (kind 2) are ignored: data bytes and TR codes produce no output.
- R3: After a JK code, data bytes of value 0xAA are skipped and the first 0xAB byte starts the frame. The frame bytes are then forwarded in arrival order, one per output cycle with `frm_valid` high, in the cycle after the symbol that releases them.
- R4: While the preamble is being skipped, a data byte other than 0xAA/0xAB, an idle (kind 0) or a TR code (kind 3) abandons the attempt. Nothing is forwarded until a new JK code arrives.
- R5: The final four data bytes of a frame are never forwarded. `frm_last` is high only together with the last forwarded byte, for exactly one cycle.
- R6: A frame ended by a TR code whose bytes (including the four trailing check bytes) form a correct Ethernet CRC-32 frame check sequence reports `frm_crc_bad` = 0.
- R7: A frame ended by a TR code whose check sequence does not match the frame contents reports `frm_crc_bad` = 1.
- R8: A frame ended by an idle or a JK code instead of a TR code reports `frm_crc_bad` = 1. An ending JK code also starts a new preamble, so a following 0xAB opens the next frame.
- R9: The two bytes at frame offsets 12 (high) and 13 (low) form the length/type value. `frm_is_length` is 1 for values 0x0000 to 0x05DC and 0 for 0x05DD to 0xFFFF.
- R10: Cycles with `sym_en` low have no effect, whatever `sym_kind` and `sym_byte` carry. `frm_valid` only rises in the cycle after an accepted symbol.
- R11: `frm_crc_bad` and `frm_is_length` are 0 in every cycle where `frm_last` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_en | input | 1 | A line symbol is present this cycle |
| sym_kind | input | 2 | Symbol tag: 0 idle, 1 data, 2 JK start, 3 TR end |
| sym_byte | input | 8 | Byte value for data symbols |
| frm_valid | output | 1 | Forwarded frame byte valid |
| frm_byte | output | 8 | Forwarded frame byte |
| frm_last | output | 1 | Last forwarded byte of the frame; status is valid |
| frm_crc_bad | output | 1 | CRC error or missing TR code (with `frm_last`) |
| frm_is_length | output | 1 | Length/type field holds a length (with `frm_last`) |

## Verification
Random frames are sent with varied payload sizes, preamble lengths, length/type values and idle gaps between symbols. These show that the byte order, the withheld tail and the CRC check hold apart from stream timing. Single-bit corruptions anywhere in the frame separate a good check sequence from a bad one. Frames closed by idle or JK show that a missing TR code is flagged even when the check sequence is correct. The JK-terminated case also shows that a JK restarts the preamble hunt. Broken preambles, streams without JK, and the length/type values 0x0000, 0x05DC, 0x05DD and 0xFFFF cover the abandon path and the classification boundary.

// File: rtl/rx_frame_decap.sv
module rx_frame_decap #(
  parameter int          TAIL    = 4,
  parameter logic [31:0] RESIDUE = 32'hDEBB20E3,
  parameter logic [15:0] LEN_MAX = 16'h05DC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_en,
  input  logic [1:0] sym_kind,
  input  logic [7:0] sym_byte,
  output logic       frm_valid,
  output logic [7:0] frm_byte,
  output logic       frm_last,
  output logic       frm_crc_bad,
  output logic       frm_is_length
);
  localparam int          D    = TAIL + 1;
  localparam int          FW   = $clog2(D + 1);
  localparam logic [FW-1:0] FULL = FW'(D);
  localparam logic [31:0] POLY = 32'hEDB88320;
  localparam logic [1:0]  K_IDLE = 2'd0, K_DATA = 2'd1, K_JK = 2'd2, K_TR = 2'd3;

  typedef enum logic [1:0] {HUNT, PRE, BODY} st_t;

  st_t             st;
  logic [7:0]      sh [D];
  logic [FW-1:0]   fill;
  logic [31:0]     crc;
  logic [3:0]      idx;
  logic [15:0]     lt;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  wire is_data = sym_kind == K_DATA;
  wire full    = fill == FULL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= HUNT;
      fill          <= '0;
      crc           <= '1;
      idx           <= '0;
      lt            <= '0;
      frm_valid     <= 1'b0;
      frm_byte      <= '0;
      frm_last      <= 1'b0;
      frm_crc_bad   <= 1'b0;
      frm_is_length <= 1'b0;
      for (int i = 0; i < D; i++) sh[i] <= '0;
    end else begin
      frm_valid     <= 1'b0;
      frm_last      <= 1'b0;
      frm_crc_bad   <= 1'b0;
      frm_is_length <= 1'b0;
      if (sym_en) begin
        case (st)
          HUNT: if (sym_kind == K_JK) st <= PRE;
          PRE: begin
            if (sym_kind == K_JK) st <= PRE;
            else if (is_data && sym_byte == 8'hAA) st <= PRE;
            else if (is_data && sym_byte == 8'hAB) begin
              st   <= BODY;
              fill <= '0;
              crc  <= '1;
              idx  <= '0;
              lt   <= '0;
            end else st <= HUNT;
          end
          BODY: begin
            if (is_data) begin
              for (int i = D - 1; i > 0; i--) sh[i] <= sh[i-1];
              sh[0] <= sym_byte;
              crc   <= crc_step(crc, sym_byte);
              if (idx != 4'd14) idx <= idx + 4'd1;
              if (idx == 4'd12) lt[15:8] <= sym_byte;
              if (idx == 4'd13) lt[7:0]  <= sym_byte;
              if (full) begin
                frm_valid <= 1'b1;
                frm_byte  <= sh[D-1];
              end else fill <= fill + 1'b1;
            end else begin
              if (full) begin
                frm_valid     <= 1'b1;
                frm_byte      <= sh[D-1];
                frm_last      <= 1'b1;
                frm_crc_bad   <= (sym_kind != K_TR) || (crc != RESIDUE);
                frm_is_length <= lt <= LEN_MAX;
              end
              fill <= '0;
              st   <= (sym_kind == K_JK) ? PRE : HUNT;
            end
          end
          default: st <= HUNT;
        endcase
      end
    end
  end

  wire unused_idle = (sym_kind == K_IDLE);
endmodule

// File: rtl/rx_frame_decap_chk.sv
module rx_frame_decap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_en,
  input logic [1:0] sym_kind,
  input logic       frm_valid,
  input logic       frm_last,
  input logic       frm_crc_bad,
  input logic       frm_is_length
);
  logic       en_q;
  logic [1:0] kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      kind_q <= 2'd0;
    end else begin
      en_q   <= sym_en;
      kind_q <= sym_kind;
    end
  end

  p_last_has_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_last |-> frm_valid);

  p_last_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_last |=> !frm_last);

  p_flags_on_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_last |-> (!frm_crc_bad && !frm_is_length));

  p_quiet_without_symbol_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !frm_valid);

  p_no_tr_is_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_last && kind_q != 2'd3) |-> frm_crc_bad);
endmodule

bind rx_frame_decap rx_frame_decap_chk u_chk (.*);

// File: tb/rx_frame_decap_test.sv
module rx_frame_decap_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_en = 1'b0;
  logic [1:0] sym_kind = 2'd0;
  logic [7:0] sym_byte = 8'd0;
  logic       frm_valid, frm_last, frm_crc_bad, frm_is_length;
  logic [7:0] frm_byte;

  rx_frame_decap uut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] rxb [256];
  bit rxl [256], rxc [256], rxt [256];
  int rxn = 0;
  logic [7:0] fb [200];
  int fl = 0;

  always @(negedge clk) if (rst_n && frm_valid && rxn < 256) begin
    rxb[rxn] = frm_byte; rxl[rxn] = frm_last;
    rxc[rxn] = frm_crc_bad; rxt[rxn] = frm_is_length;
    rxn++;
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fcs_of(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, fb[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic build(input int pay, input logic [15:0] lt);
    logic [31:0] f;
    for (int i = 0; i < 12; i++) fb[i] = 8'($urandom);
    fb[12] = lt[15:8]; fb[13] = lt[7:0];
    for (int i = 0; i < pay; i++) fb[14+i] = 8'($urandom);
    f = fcs_of(14 + pay);
    for (int i = 0; i < 4; i++) fb[14+pay+i] = f[8*i +: 8];
    fl = 18 + pay;
  endtask

  task automatic put(input logic [1:0] k, input logic [7:0] b);
    int g = $urandom_range(0, 2);
    for (int i = 0; i < g; i++) begin
      @(negedge clk); sym_en = 1'b0; sym_kind = 2'($urandom); sym_byte = 8'($urandom);
    end
    @(negedge clk); sym_en = 1'b1; sym_kind = k; sym_byte = b;
    @(negedge clk); sym_en = 1'b0; sym_kind = 2'($urandom); sym_byte = 8'($urandom);
  endtask

  task automatic send_body(input logic [1:0] endk);
    for (int i = 0; i < fl; i++) put(2'd1, fb[i]);
    put(endk, 8'h00);
  endtask

  task automatic send_pre;
    int n = $urandom_range(0, 7);
    for (int i = 0; i < n; i++) put(2'd1, 8'hAA);
    put(2'd1, 8'hAB);
  endtask

  task automatic send_frame(input logic [1:0] endk);
    put(2'd2, 8'($urandom));
    send_pre();
    send_body(endk);
  endtask

  task automatic expect_frame(input string req, input bit crc_exp);
    bit islen = {fb[12], fb[13]} <= 16'h05DC;
    int nexp = fl - 4;
    int bmis = 0, lmis = 0, fmis = 0;
    repeat (3) @(negedge clk);
    chk(rxn == nexp, "R5", "forwarded byte count", rxn, nexp);
    if (rxn == nexp) begin
      for (int i = 0; i < rxn; i++) begin
        if (rxb[i] !== fb[i]) bmis++;
        if (rxl[i] !== (i == rxn - 1)) lmis++;
        if (i != rxn - 1 && (rxc[i] || rxt[i])) fmis++;
      end
      chk(bmis == 0, "R3", "mismatched bytes", bmis, 0);
      chk(lmis == 0, "R5", "misplaced last flags", lmis, 0);
      chk(fmis == 0, "R11", "flags before last", fmis, 0);
      chk(rxc[rxn-1] == crc_exp, req, "crc_bad", rxc[rxn-1], crc_exp);
      chk(rxt[rxn-1] == islen, "R9", "is_length", rxt[rxn-1], islen);
    end
    rxn = 0;
  endtask

  task automatic expect_none(input string req);
    repeat (3) @(negedge clk);
    chk(rxn == 0, req, "bytes forwarded", rxn, 0);
    rxn = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!frm_valid && !frm_last && !frm_crc_bad && !frm_is_length, "R1", "outputs in reset",
        {frm_valid, frm_last, frm_crc_bad, frm_is_length}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!frm_valid && !frm_last && !frm_crc_bad && !frm_is_length, "R1", "outputs after reset",
        {frm_valid, frm_last, frm_crc_bad, frm_is_length}, 0);
    rxn = 0;

    // R2: no JK code at all
    build(46, 16'h0800);
    put(2'd1, 8'hAA); put(2'd1, 8'hAB);
    send_body(2'd3);
    expect_none("R2");

    // R4: broken preamble byte, then idle and TR in preamble
    put(2'd2, 8'h00); put(2'd1, 8'hAA); put(2'd1, 8'h5A); put(2'd1, 8'hAB);
    send_body(2'd3);
    expect_none("R4");
    put(2'd2, 8'h00); put(2'd0, 8'h00); put(2'd1, 8'hAB);
    send_body(2'd3);
    expect_none("R4");
    put(2'd2, 8'h00); put(2'd1, 8'hAA); put(2'd3, 8'h00); put(2'd1, 8'hAB);
    send_body(2'd3);
    expect_none("R4");

    // R3 R6 R9 random good frames
    for (int n = 0; n < 24; n++) begin
      logic [15:0] lt = ($urandom_range(0, 1) == 1) ? 16'($urandom_range(0, 16'h05DC)) : 16'($urandom);
      build($urandom_range(0, 80), lt);
      send_frame(2'd3);
      expect_frame("R6", 1'b0);
    end

    // R9 boundaries
    build(46, 16'h05DC); send_frame(2'd3); expect_frame("R6", 1'b0);
    build(46, 16'h05DD); send_frame(2'd3); expect_frame("R6", 1'b0);
    build(50, 16'h0000); send_frame(2'd3); expect_frame("R6", 1'b0);
    build(50, 16'hFFFF); send_frame(2'd3); expect_frame("R6", 1'b0);

    // R7 corrupted frames
    for (int n = 0; n < 6; n++) begin
      int p;
      build($urandom_range(10, 60), 16'($urandom));
      p = $urandom_range(0, fl - 1);
      fb[p] = fb[p] ^ (8'h01 << $urandom_range(0, 7));
      send_frame(2'd3);
      expect_frame("R7", 1'b1);
    end

    // R8 missing TR: idle end, then JK end followed by restart without new JK
    build(46, 16'h0600); send_frame(2'd0); expect_frame("R8", 1'b1);
    build(46, 16'h0040); send_frame(2'd2); expect_frame("R8", 1'b1);
    build(46, 16'h0800); send_pre(); send_body(2'd3); expect_frame("R8", 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule